// File: doc/BRIEF.md
# Earliest-Hit Channel Address Encoder

This block watches a bank of discriminator outputs, one per detector channel, and reports once per bunch-crossing period which channel went above threshold first during that period. A single-cycle crossing strobe divides time into windows. Within a window, the first clock cycle that shows any enabled hit is captured. If several channels rise in that same cycle, a fixed rule picks one of them. Any activity later in the same window is ignored.

When the next strobe arrives, the captured result moves to the registered outputs and stays there for the whole following period. In the same cycle the capture logic re-arms. The valid flag tells whether any enabled channel fired in the window, so it serves as a fast OR trigger primitive. A separate any-hit bit follows the enabled hits cycle by cycle. A per-channel mask removes noisy channels from every output. Crossings nominally occur at 40 MHz, and the system clock is a multiple of that rate.

Top module: `first_hit_encoder`

## Requirements
- R1: The channel count is a parameter with a default of 64, and the address output is clog2 of it wide (6 bits by default), so channel 63 is reported as 63.
- R2: A window begins with the clock cycle in which `bx_strobe` is 1 and ends with the cycle before the next strobe. The outputs `hit_addr` and `hit_valid` change only at a clock edge where `bx_strobe` is 1, and they then show the result of the window that this strobe closes. Before the first strobe after reset they stay 0, whatever the hits are.
- R3: `hit_addr` is the index of the channel that is high and unmasked in the earliest cycle of the window in which any unmasked channel is high.
- R4: If several unmasked channels are high in that earliest cycle, the lowest index is reported. This is the default tie mode.
- R5: After a capture, hits in later cycles of the same window do not change the result, even on lower-index channels.
- R6: A channel whose `ch_mask` bit is 1 counts as never hit. It affects neither `hit_addr`, `hit_valid` nor `any_hit`.
- R7: `hit_valid` is 1 exactly when some unmasked channel was high in at least one cycle of the window. When `hit_valid` is 0, `hit_addr` is 0.
- R8: `any_hit` is the OR of the unmasked hits, registered, so it follows the inputs one clock later.
- R9: Between strobes, `hit_addr` and `hit_valid` hold their values no matter how the hit inputs change.
- R10: While `rst_n` is 0, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bx_strobe | input | 1 | One-cycle pulse that starts a crossing window |
| ch_hit | input | NUM_CH | Discriminator level per channel, 1 = above threshold |
| ch_mask | input | NUM_CH | 1 = channel excluded |
| hit_addr | output | ADDR_W | Earliest channel of the last closed window |
| hit_valid | output | 1 | Fast OR over the last closed window |
| any_hit | output | 1 | Registered OR of unmasked hits this cycle |

## Verification
The windows in the vector table are chosen to tell earliest-in-time apart from priority-at-sampling. In some windows a low-index channel fires after a high-index one, and the high-index one must still be reported. Other windows contain same-cycle ties, the channel in the top position, masked channels that fire earliest, empty windows and fully masked windows. After each closing strobe the bench floods the inputs to show that the outputs hold. Directed cases cover the outputs before the first strobe and the any-hit path with and without a mask.

// File: rtl/fhe_pkg.sv
package fhe_pkg;
   // Same-cycle tie resolution for the priority tree
   typedef enum logic {
      TIE_LOW  = 1'b0,
      TIE_HIGH = 1'b1
   } tie_mode_e;

   function automatic int addr_bits(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/fhe_qualify.sv
// Applies the channel mask and produces the registered any-hit flag.
module fhe_qualify #(
   parameter int NUM_CH = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] hit,
   input  logic [NUM_CH-1:0] mask,
   output logic [NUM_CH-1:0] act,
   output logic              any_q
);
   assign act = hit & ~mask;

   always_ff @(posedge clk) begin
      if (!rst_n) any_q <= 1'b0;
      else        any_q <= |act;
   end
endmodule

// File: rtl/fhe_prio_tree.sv
// Balanced binary tree: each node forwards one (found, index) pair from its two children.
module fhe_prio_tree #(
   parameter int                  NUM_CH   = 64,
   parameter int                  ADDR_W   = 6,
   parameter fhe_pkg::tie_mode_e  TIE_MODE = fhe_pkg::TIE_LOW
) (
   input  logic [NUM_CH-1:0] req,
   output logic              found,
   output logic [ADDR_W-1:0] idx
);
   localparam int LEAVES = 1 << ADDR_W;
   localparam int NODES  = 2 * LEAVES - 1;
   localparam int FIRST_LEAF = LEAVES - 1;

   logic              nv [NODES];
   logic [ADDR_W-1:0] ni [NODES];

   for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
      if (j < NUM_CH) begin : g_real
         assign nv[FIRST_LEAF+j] = req[j];
      end else begin : g_pad
         assign nv[FIRST_LEAF+j] = 1'b0;
      end
      assign ni[FIRST_LEAF+j] = ADDR_W'(j);
   end

   for (genvar k = 0; k < FIRST_LEAF; k++) begin : g_node
      assign nv[k] = nv[2*k+1] | nv[2*k+2];
      if (TIE_MODE == fhe_pkg::TIE_LOW) begin : g_low
         assign ni[k] = nv[2*k+1] ? ni[2*k+1] : ni[2*k+2];
      end else begin : g_high
         assign ni[k] = nv[2*k+2] ? ni[2*k+2] : ni[2*k+1];
      end
   end

   assign found = nv[0];
   assign idx   = nv[0] ? ni[0] : '0;
endmodule

// File: rtl/fhe_window_capture.sv
// Holds the first capture of the open window and publishes it at the strobe.
module fhe_window_capture #(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bx_strobe,
   input  logic              found,
   input  logic [ADDR_W-1:0] idx,
   output logic [ADDR_W-1:0] out_addr,
   output logic              out_valid
);
   logic              cap_v;
   logic [ADDR_W-1:0] cap_a;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_v     <= 1'b0;
         cap_a     <= '0;
         out_valid <= 1'b0;
         out_addr  <= '0;
      end else if (bx_strobe) begin
         out_valid <= cap_v;
         out_addr  <= cap_v ? cap_a : '0;
         cap_v     <= found;
         cap_a     <= found ? idx : '0;
      end else if (!cap_v && found) begin
         cap_v <= 1'b1;
         cap_a <= idx;
      end
   end
endmodule

// File: rtl/first_hit_encoder.sv
module first_hit_encoder #(
   parameter int                  NUM_CH   = 64,
   parameter fhe_pkg::tie_mode_e  TIE_MODE = fhe_pkg::TIE_LOW,
   parameter int                  ADDR_W   = fhe_pkg::addr_bits(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bx_strobe,
   input  logic [NUM_CH-1:0] ch_hit,
   input  logic [NUM_CH-1:0] ch_mask,
   output logic [ADDR_W-1:0] hit_addr,
   output logic              hit_valid,
   output logic              any_hit
);
   if (NUM_CH < 2) begin : g_chk_min
      $error("first_hit_encoder: NUM_CH must be at least 2");
   end
   if (NUM_CH > 1024) begin : g_chk_max
      $error("first_hit_encoder: NUM_CH above 1024 not supported");
   end
   if ((1 << ADDR_W) < NUM_CH) begin : g_chk_w
      $error("first_hit_encoder: ADDR_W too narrow for NUM_CH");
   end

   logic [NUM_CH-1:0] act;
   logic              found;
   logic [ADDR_W-1:0] idx;

   fhe_qualify #(.NUM_CH(NUM_CH)) u_qual (
      .clk(clk), .rst_n(rst_n), .hit(ch_hit), .mask(ch_mask),
      .act(act), .any_q(any_hit)
   );

   fhe_prio_tree #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .TIE_MODE(TIE_MODE)) u_tree (
      .req(act), .found(found), .idx(idx)
   );

   fhe_window_capture #(.ADDR_W(ADDR_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .bx_strobe(bx_strobe),
      .found(found), .idx(idx),
      .out_addr(hit_addr), .out_valid(hit_valid)
   );
endmodule

// File: rtl/fhe_checker.sv
module fhe_checker #(
   parameter int NUM_CH = 64,
   parameter int ADDR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bx_strobe,
   input logic [NUM_CH-1:0] ch_hit,
   input logic [NUM_CH-1:0] ch_mask,
   input logic [ADDR_W-1:0] hit_addr,
   input logic              hit_valid,
   input logic              any_hit
);
   logic win_any;
   wire  live = |(ch_hit & ~ch_mask);

   always_ff @(posedge clk) begin
      if (!rst_n)         win_any <= 1'b0;
      else if (bx_strobe) win_any <= live;
      else                win_any <= win_any | live;
   end

   AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
      !bx_strobe |=> ($stable(hit_addr) && $stable(hit_valid))); // R9
   AST_VALID_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      bx_strobe |=> (hit_valid == $past(win_any))); // R7
   AST_IDLE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_valid |-> (hit_addr == '0)); // R7
   AST_ANY_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (any_hit == $past(live))); // R8
   AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      hit_valid |-> (int'(hit_addr) < NUM_CH)); // R1
endmodule

bind first_hit_encoder fhe_checker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bx_strobe(bx_strobe), .ch_hit(ch_hit),
   .ch_mask(ch_mask), .hit_addr(hit_addr), .hit_valid(hit_valid), .any_hit(any_hit)
);

// File: tb/first_hit_encoder_tb.sv
module first_hit_encoder_tb;
   localparam int N  = 64;
   localparam int AW = 6;
   localparam int NV = 8;
   localparam logic [63:0] ONES = {64{1'b1}};

   // per window: hits in cycle 0 (strobe), 1, 2; mask; expected addr, valid
   localparam logic [63:0] H0 [NV] = '{64'h0, 64'h8000_0000_0000_0000, 64'h0, 64'h8,
                                       64'h0, ONES, ONES, 64'h0};
   localparam logic [63:0] H1 [NV] = '{64'h0000_0100_0000_0020, 64'h1, 64'h0, 64'h10_0000,
                                       64'h0, ONES, 64'h0, 64'h2_0000_0000};
   localparam logic [63:0] H2 [NV] = '{64'h4, 64'h0, 64'h600, 64'h0,
                                       64'h0, ONES, 64'h0, 64'h1};
   localparam logic [63:0] MK [NV] = '{64'h0, 64'h0, 64'h0, 64'h8,
                                       64'h0, ONES, 64'h0, 64'h0};
   localparam int          EA [NV] = '{5, 63, 9, 20, 0, 0, 0, 33};
   localparam logic        EV [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};
   localparam string       TAG[NV] = '{"R4", "R1", "R3", "R6", "R7", "R6", "R4", "R5"};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bx_strobe = 1'b0;
   logic [N-1:0]  ch_hit = '0;
   logic [N-1:0]  ch_mask = '0;
   logic [AW-1:0] hit_addr;
   logic          hit_valid;
   logic          any_hit;
   int            errors = 0;
   int            checks = 0;
   bit            done = 1'b0;

   always #10 clk = ~clk;

   first_hit_encoder u_dut (
      .clk(clk), .rst_n(rst_n), .bx_strobe(bx_strobe), .ch_hit(ch_hit),
      .ch_mask(ch_mask), .hit_addr(hit_addr), .hit_valid(hit_valid), .any_hit(any_hit)
   );

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // called at a falling edge; drives inputs and returns at the next falling edge
   task automatic tick(input logic s, input logic [N-1:0] h, input logic [N-1:0] m);
      bx_strobe = s;
      ch_hit    = h;
      ch_mask   = m;
      @(negedge clk);
   endtask

   initial begin
      @(negedge clk);
      tick(0, ONES, 64'h0);
      // R10: reset holds everything at 0
      check("R10 addr", hit_addr, 0);
      check("R10 valid", hit_valid, 0);
      check("R10 any", any_hit, 0);
      rst_n = 1'b1;
      // R2: no strobe yet, outputs stay 0 despite hits
      tick(0, 64'h10, 64'h0);
      tick(0, 64'h10, 64'h0);
      check("R2 valid before strobe", hit_valid, 0);
      check("R2 addr before strobe", hit_addr, 0);
      // R8: registered fast OR
      tick(0, 64'h80, 64'h0);
      check("R8 any set", any_hit, 1);
      tick(0, 64'h0, 64'h0);
      check("R8 any clear", any_hit, 0);
      tick(0, 64'h80, 64'h80);
      check("R6 any masked", any_hit, 0);

      for (int e = 0; e < NV; e++) begin
         tick(1, H0[e], MK[e]);
         tick(0, H1[e], MK[e]);
         tick(0, H2[e], MK[e]);
         tick(1, 64'h0, 64'h0);
         check({TAG[e], " addr"}, hit_addr, EA[e]);
         check({TAG[e], " valid"}, hit_valid, EV[e]);
         tick(0, ONES, 64'h0);
         tick(0, 64'h5, 64'h0);
         check("R9 addr held", hit_addr, EA[e]);
         check("R9 valid held", hit_valid, EV[e]);
      end

      // R2: a hit in the strobe cycle belongs to the new window
      tick(1, 64'h0, 64'h0);
      tick(1, 64'h4000, 64'h0);
      check("R2 old window empty", hit_valid, 0);
      tick(1, 64'h0, 64'h0);
      check("R2 strobe-cycle hit addr", hit_addr, 14);
      check("R2 strobe-cycle hit valid", hit_valid, 1);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule